// File: doc/BRIEF.md
# Split Wide Immediate Compare Unit

This execution unit compares a 64-bit register value against a 64-bit immediate as two separate instructions. The first instruction (the high step) compares only bits 63..24 of the two values and writes a four-bit flag word into a chosen entry of a small flag register file. The second instruction (the low step) compares bits 23..0. It does so only when the Z flag already held in its chosen entry is set. Otherwise it is a no-operation.

The immediate goes straight into the comparator, so no scratch register has to be loaded with it first. The only state carried from the high step to the low step is the architectural flag register. An interrupt between the two steps therefore loses nothing. The compare runs from the most significant part down to the least significant part. The low step never has to correct flags that the high step has already settled.

For the low step, both operands get bits 63..24 filled with the sign bit of the source value before they are subtracted. This keeps the signed result of the pair correct. A write is registered one clock after the valid strobe and is reported on a write port. A combinational read port exposes every entry.

Top module: `wide_imm_cmp`

## Requirements
- R1: After reset, all 8 flag registers read 0 and `wr_en` is low.
- R2: Each write places the flag word in bits 3..0 as N=bit3, V=bit2, C=bit1, Z=bit0, with bits 63..4 zero. The write lands in entry `dst_idx` at the first rising edge after the valid cycle. In the cycle that follows, `wr_en` is high and `wr_idx`/`wr_data` show that write.
- R3: A high step (`in_lower`=0) always writes. It treats bits 63..24 of the source and immediate as 40-bit values a and b: Z is a==b, C is unsigned a<b, N is bit 39 of a-b, and V is signed overflow of the 40-bit subtraction a-b.
- R4: A low step (`in_lower`=1) whose target entry has Z=1 writes flags for the 24-bit fields x=src[23:0] and y=imm[23:0]: Z is x==y, C is x<y, N is x<y, and V is 0. Both operands are sign-filled from src bit 63.
- R5: A low step whose target entry has Z=0 writes nothing: `wr_en` stays low and the entry keeps its old value.
- R6: After a high step followed by a low step on the same entry, the entry matches a full 64-bit compare: Z is src==imm, C is unsigned src<imm, and N xor V is signed src<imm.
- R7: A low step issued in the cycle right after the high step to the same entry sees the Z flag that the high step just wrote.
- R8: In a cycle with `in_valid` low, no register changes and `wr_en` is low in the next cycle. A write changes only its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction valid strobe |
| in_lower | input | 1 | 0 = high step (bits 63..24), 1 = low step (bits 23..0) |
| dst_idx | input | 3 | Target flag register |
| src_val | input | 64 | Source register value |
| imm_val | input | 64 | Immediate from the instruction |
| rd_idx | input | 3 | Read port index |
| rd_data | output | 64 | Read port data (combinational) |
| wr_en | output | 1 | A flag write happened at the last edge |
| wr_idx | output | 3 | Entry written |
| wr_data | output | 64 | Value written |

## Verification
The hardest situation to reach is a low step that must be skipped even though its own 24-bit fields would compare in a useful way. The bench gets there by pairing sources and immediates whose high parts differ while their low parts are equal or ordered. It also aims a low step at a reset entry and at an entry a high step has just cleared. The reverse case needs equal high parts, and random stimulus almost never produces them. The bench therefore builds most random immediates by copying the source's high 40 bits. It sweeps sign-boundary and 24-bit-boundary values in all pairings, and it issues one pair back to back with no idle cycle between the steps.

// File: rtl/wide_imm_cmp.sv
module wide_imm_cmp #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 24,
  parameter int NREGS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_lower,
  input  logic [$clog2(NREGS)-1:0] dst_idx,
  input  logic [DATA_W-1:0]        src_val,
  input  logic [DATA_W-1:0]        imm_val,
  input  logic [$clog2(NREGS)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     wr_en,
  output logic [$clog2(NREGS)-1:0] wr_idx,
  output logic [DATA_W-1:0]        wr_data
);
  localparam int HI_W = DATA_W - LOW_W;

  logic [DATA_W-1:0] regs [NREGS];
  logic              sgn;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W:0]   diff;
  logic [3:0]        flags;
  logic              tgt_z, do_wr;
  logic [DATA_W-1:0] new_val;

  assign sgn = src_val[DATA_W-1];
  assign opa = in_lower ? {{HI_W{sgn}}, src_val[LOW_W-1:0]}
                        : {src_val[DATA_W-1:LOW_W], {LOW_W{1'b0}}};
  assign opb = in_lower ? {{HI_W{sgn}}, imm_val[LOW_W-1:0]}
                        : {imm_val[DATA_W-1:LOW_W], {LOW_W{1'b0}}};
  assign diff = {1'b0, opa} - {1'b0, opb};

  assign flags = {diff[DATA_W-1],
                  (opa[DATA_W-1] ^ opb[DATA_W-1]) & (diff[DATA_W-1] ^ opa[DATA_W-1]),
                  diff[DATA_W],
                  diff[DATA_W-1:0] == '0};

  assign tgt_z   = regs[dst_idx][0];
  assign do_wr   = in_valid & (~in_lower | tgt_z);
  assign new_val = {{(DATA_W-4){1'b0}}, flags};
  assign rd_data = regs[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= do_wr;
      if (do_wr) begin
        regs[dst_idx] <= new_val;
        wr_idx        <= dst_idx;
        wr_data       <= new_val;
      end
    end
  end
endmodule

// File: rtl/wide_imm_cmp_chk.sv
module wide_imm_cmp_chk #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_lower,
  input logic [$clog2(NREGS)-1:0] dst_idx,
  input logic                     wr_en,
  input logic [$clog2(NREGS)-1:0] wr_idx,
  input logic [DATA_W-1:0]        wr_data
);
  a_r2_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));

  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[DATA_W-1:4] == '0);

  a_r2_index_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!wr_en || wr_idx == $past(dst_idx)));

  a_r3_high_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_lower) |=> wr_en);

  a_r3_equal_clears_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |-> wr_data[3:1] == 3'b000);

  a_r4_low_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lower) |=> (!wr_en || !wr_data[2]));

  a_r4_low_n_equals_c: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lower) |=> (!wr_en || wr_data[3] == wr_data[1]));

  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en);
endmodule

bind wide_imm_cmp wide_imm_cmp_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lower(in_lower),
  .dst_idx(dst_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

// File: tb/wide_imm_cmp_tb.sv
module wide_imm_cmp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_lower = 1'b0;
  logic [2:0]  dst_idx = '0;
  logic [63:0] src_val = '0;
  logic [63:0] imm_val = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [63:0] wr_data;

  int total = 0;
  int bad = 0;
  logic [63:0] shadow [8];

  wide_imm_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lower(in_lower),
    .dst_idx(dst_idx), .src_val(src_val), .imm_val(imm_val),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] hi_flags(input logic [63:0] s, input logic [63:0] m);
    logic [39:0] a, b;
    logic [40:0] ex;
    a  = s[63:24];
    b  = m[63:24];
    ex = {a[39], a} - {b[39], b};
    return {ex[39], ex[40] ^ ex[39], a < b, a == b};
  endfunction

  function automatic logic [3:0] lo_flags(input logic [63:0] s, input logic [63:0] m);
    logic lt;
    lt = s[23:0] < m[23:0];
    return {lt, 1'b0, lt, s[23:0] == m[23:0]};
  endfunction

  task automatic read_reg(input int idx, output logic [63:0] v);
    rd_idx = idx[2:0];
    #1;
    v = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      chk(v == shadow[i], req, v, shadow[i]);
    end
  endtask

  task automatic issue(input bit lower, input int d, input logic [63:0] s, input logic [63:0] m);
    bit will;
    logic [3:0] f;
    will = !lower || shadow[d][0];
    f = lower ? lo_flags(s, m) : hi_flags(s, m);
    in_valid = 1'b1; in_lower = lower; dst_idx = d[2:0]; src_val = s; imm_val = m;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (will) begin
      shadow[d] = {60'b0, f};
      chk(wr_en == 1'b1, lower ? "R4 wr_en" : "R3 wr_en", {63'b0, wr_en}, 64'd1);
      chk(wr_idx == d[2:0], "R2 wr_idx", {61'b0, wr_idx}, d);
      chk(wr_data == shadow[d], lower ? "R4 flags" : "R3 flags", wr_data, shadow[d]);
    end else begin
      chk(wr_en == 1'b0, "R5 skipped low step", {63'b0, wr_en}, 64'd0);
    end
  endtask

  task automatic pair(input int d, input logic [63:0] s, input logic [63:0] m);
    logic [63:0] v;
    logic z, c, lt;
    issue(0, d, s, m);
    issue(1, d, s, m);
    read_reg(d, v);
    z = v[0]; c = v[1]; lt = v[3] ^ v[2];
    chk(z == (s == m), "R6 Z full", v, {63'b0, s == m});
    chk(c == (s < m), "R6 C full", v, {63'b0, s < m});
    chk(lt == ($signed(s) < $signed(m)), "R6 signed lt", v, {63'b0, $signed(s) < $signed(m)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] bnd [12];
    logic [63:0] v;
    bnd[0]  = 64'h0;
    bnd[1]  = 64'h1;
    bnd[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
    bnd[3]  = 64'h8000_0000_0000_0000;
    bnd[4]  = 64'h7FFF_FFFF_FFFF_FFFF;
    bnd[5]  = 64'h0000_0000_00FF_FFFF;
    bnd[6]  = 64'h0000_0000_0100_0000;
    bnd[7]  = 64'hFFFF_FFFF_FF00_0000;
    bnd[8]  = 64'h8000_0000_00FF_FFFF;
    bnd[9]  = 64'h7FFF_FFFF_FF00_0000;
    bnd[10] = 64'h0000_0098_7654_3210;
    bnd[11] = 64'h0000_0098_7600_0000;
    for (int i = 0; i < 8; i++) shadow[i] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(wr_en == 1'b0, "R1 wr_en after reset", {63'b0, wr_en}, 64'd0);
    check_all("R1 reset regs");

    // R5: low step aimed at a reset entry (Z=0)
    issue(1, 2, 64'h5, 64'h5);
    check_all("R5 entry unchanged");

    // R5: high parts differ, so the low step is skipped and the high flags stay
    issue(0, 3, 64'h0000_0001_0000_0005, 64'h0000_0002_0000_0005);
    issue(1, 3, 64'h0000_0001_0000_0005, 64'h0000_0002_0000_0005);
    check_all("R5 flags kept");

    // R8: idle cycles cause no write
    @(negedge clk);
    chk(wr_en == 1'b0, "R8 idle", {63'b0, wr_en}, 64'd0);
    @(negedge clk);
    check_all("R8 idle regs");

    // R7: back to back pair with no idle cycle
    in_valid = 1'b1; in_lower = 1'b0; dst_idx = 3'd5;
    src_val = 64'hABCD_EF01_2300_0010; imm_val = 64'hABCD_EF01_2300_0020;
    @(posedge clk);
    @(negedge clk);
    in_lower = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    shadow[5] = {60'b0, lo_flags(64'hABCD_EF01_2300_0010, 64'hABCD_EF01_2300_0020)};
    chk(wr_en == 1'b1, "R7 low step wrote", {63'b0, wr_en}, 64'd1);
    read_reg(5, v);
    chk(v == shadow[5], "R7 back-to-back flags", v, shadow[5]);
    check_all("R8 other entries");

    // Boundary sweep over all pairings
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        pair((i + j) % 8, bnd[i], bnd[j]);
    check_all("R8 after sweep");

    // Random operands, mostly with equal high parts
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] s, m;
      s = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (k % 4 != 0) m[63:24] = s[63:24];
      if (k % 16 == 1) m[23:0] = s[23:0];
      pair(k % 8, s, m);
    end
    check_all("R8 after random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule